// File: doc/BRIEF.md
# HDLC Frame Header Parser

This block reads the octets of one received HDLC frame after flag stripping and zero-bit removal. It locates the address and control fields and decodes the control field into frame class, send and receive sequence numbers, poll/final bit, supervisory code and unnumbered modifier bits. Three framings are supported: single-octet address with 3-bit sequence numbers, single-octet address with 7-bit sequence numbers, and two-octet address with 7-bit sequence numbers. The header length depends on the framing and on the frame class, so the parser finds the end of the header while the octets arrive.

Octets come one per cycle when `byte_valid_i` is high. `sof_i` marks the first octet of a frame and `eof_i` marks the last one. The last two octets of every frame are the check sequence. The parser does not verify them. It counts the octets between the header and the check sequence and reports the two check octets. Frames too short to hold a header and a check sequence are flagged, and no header result is produced for them.

Top module: `hdlc_hdr_parser`

## Requirements
- R1: `mode_i` is sampled on the start octet. 00 selects 3-bit numbering with a one-octet address, 01 selects 7-bit numbering with a one-octet address, and 10 or 11 selects 7-bit numbering with a two-octet address. The first control octet follows the address, and `info_off_o` reports the header length in octets (address plus control).
- R2: Bit 0 of the first control octet equal to 0 gives class I (`frame_type_o`=00). Bits 1:0 equal to 01 give class S (01). Bits 1:0 equal to 11 give class U (10).
- R3: With 3-bit numbering, I and S frames have one control octet. `nr_o`=bits 7:5 and `pf_o`=bit 4. For I, `ns_o`=bits 3:1. For S, `s_code_o`=bits 3:2. Fields that are not used read 0.
- R4: A U frame always has one control octet, in every mode. `u_mod_o`={bits 7:5, bits 3:2} and `pf_o`=bit 4. `ns_o`, `nr_o` and `s_code_o` read 0.
- R5: With 7-bit numbering, I and S frames have two control octets. For I, `ns_o`=octet1 bits 7:1. For S, `s_code_o`=octet1 bits 3:2. For both, `nr_o`=octet2 bits 7:1 and `pf_o`=octet2 bit 0.
- R6: `rsvd_warn_o` is 1 for a two-octet S frame whose first control octet has any of bits 7:4 set, and 0 for every other frame. Such a frame is still decoded.
- R7: `hdr_valid_o` is a one-cycle pulse in the cycle after the octet at offset header length + 1 is accepted, that is once the header and two more octets have arrived. The decoded fields and `info_off_o` hold their values from then until the next frame's header.
- R8: In the cycle after an accepted end octet of a frame of at least header + 2 octets, `frame_done_o` pulses. `info_len_o` = total − header − 2, and `fcs_o` = the last two octets, with the earlier one in bits 15:8.
- R9: A frame that ends with fewer than header + 2 octets pulses `short_err_o` in the cycle after its end octet. It raises neither `hdr_valid_o` nor `frame_done_o`.
- R10: Octets with `byte_valid_i` low, and valid octets outside a frame, have no effect. A start octet in the middle of a frame restarts parsing. `mode_i` is ignored on octets that are not start octets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| mode_i | input | 2 | framing select, sampled on the start octet |
| byte_valid_i | input | 1 | octet strobe |
| byte_i | input | 8 | octet data |
| sof_i | input | 1 | first octet of frame |
| eof_i | input | 1 | last octet of frame |
| hdr_valid_o | output | 1 | header decoded pulse |
| frame_type_o | output | 2 | 00 I, 01 S, 10 U |
| ns_o | output | 7 | send sequence number |
| nr_o | output | 7 | receive sequence number |
| pf_o | output | 1 | poll/final |
| s_code_o | output | 2 | supervisory code |
| u_mod_o | output | 5 | unnumbered modifier bits |
| rsvd_warn_o | output | 1 | reserved bits set in two-octet S control |
| info_off_o | output | 3 | header length in octets |
| frame_done_o | output | 1 | frame complete pulse |
| info_len_o | output | 12 | information field length |
| fcs_o | output | 16 | received check octets |
| short_err_o | output | 1 | frame too short pulse |

## Verification
Each result is due exactly one clock after the octet that completes it. The header fields and `hdr_valid_o` follow the octet at offset header + 1, and `frame_done_o`, `info_len_o`, `fcs_o` and `short_err_o` follow the end octet. The bench drives each octet at a falling edge and samples 1 ns after the next rising edge. At that point it compares the pulses against values predicted from the octet index, the frame length and the header length. The header length is computed from the frame contents. Idle cycles between octets carry random start and end markers with the strobe low, so a design that does not ignore them is caught.

// File: rtl/hdlc_hdr_pkg.sv
package hdlc_hdr_pkg;
  localparam int SEQ_W = 7;
  localparam int OFF_W = 3;

  typedef enum logic [1:0] {
    FT_I = 2'b00,
    FT_S = 2'b01,
    FT_U = 2'b10
  } frame_t;

  localparam logic [1:0] MODE_SEQ8 = 2'b00;

  typedef struct packed {
    frame_t             ftype;
    logic [SEQ_W-1:0]   ns;
    logic [SEQ_W-1:0]   nr;
    logic               pf;
    logic [1:0]         s_code;
    logic [4:0]         u_mod;
    logic               rsvd_warn;
  } hdr_fields_t;
endpackage

// File: rtl/hdlc_pos_counter.sv
module hdlc_pos_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_valid_i,
  input  logic             sof_i,
  input  logic             eof_i,
  output logic             take_o,
  output logic [CNT_W-1:0] pos_o
);
  logic             in_frame_q;
  logic [CNT_W-1:0] cnt_q;

  assign take_o = byte_valid_i && (sof_i || in_frame_q);
  assign pos_o  = sof_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
    end else if (take_o) begin
      in_frame_q <= !eof_i;
      // saturate on very long frames
      if (pos_o != '1) cnt_q <= pos_o + CNT_W'(1);
      else             cnt_q <= pos_o;
    end
  end
endmodule

// File: rtl/hdlc_ctrl_decode.sv
module hdlc_ctrl_decode
  import hdlc_hdr_pkg::*;
(
  input  logic        ext_seq_i,
  input  logic [7:0]  c0_i,
  input  logic [7:0]  c1_i,
  output hdr_fields_t fld_o,
  output logic        two_oct_o
);
  always_comb begin
    fld_o = '0;
    if (!c0_i[0])      fld_o.ftype = FT_I;
    else if (!c0_i[1]) fld_o.ftype = FT_S;
    else               fld_o.ftype = FT_U;

    unique case (fld_o.ftype)
      FT_I: begin
        if (ext_seq_i) begin
          fld_o.ns = c0_i[7:1];
          fld_o.nr = c1_i[7:1];
          fld_o.pf = c1_i[0];
        end else begin
          fld_o.ns = SEQ_W'(c0_i[3:1]);
          fld_o.nr = SEQ_W'(c0_i[7:5]);
          fld_o.pf = c0_i[4];
        end
      end
      FT_S: begin
        fld_o.s_code = c0_i[3:2];
        if (ext_seq_i) begin
          fld_o.nr        = c1_i[7:1];
          fld_o.pf        = c1_i[0];
          fld_o.rsvd_warn = |c0_i[7:4];
        end else begin
          fld_o.nr = SEQ_W'(c0_i[7:5]);
          fld_o.pf = c0_i[4];
        end
      end
      default: begin
        fld_o.u_mod = {c0_i[7:5], c0_i[3:2]};
        fld_o.pf    = c0_i[4];
      end
    endcase
  end

  assign two_oct_o = ext_seq_i && (fld_o.ftype != FT_U);
endmodule

// File: rtl/hdlc_octet_hist.sv
module hdlc_octet_hist (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        take_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] last2_o
);
  logic [7:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prev_q <= '0;
    else if (take_i) prev_q <= byte_i;
  end

  assign last2_o = {prev_q, byte_i};
endmodule

// File: rtl/hdlc_hdr_parser.sv
module hdlc_hdr_parser
  import hdlc_hdr_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  input  logic             sof_i,
  input  logic             eof_i,
  output logic             hdr_valid_o,
  output logic [1:0]       frame_type_o,
  output logic [6:0]       ns_o,
  output logic [6:0]       nr_o,
  output logic             pf_o,
  output logic [1:0]       s_code_o,
  output logic [4:0]       u_mod_o,
  output logic             rsvd_warn_o,
  output logic [2:0]       info_off_o,
  output logic             frame_done_o,
  output logic [CNT_W-1:0] info_len_o,
  output logic [15:0]      fcs_o,
  output logic             short_err_o
);
  logic             take;
  logic [CNT_W-1:0] pos;
  logic [1:0]       mode_q, mode_eff;
  logic             ext_seq;
  logic [CNT_W-1:0] addr_len;
  logic             at_c0, last_ctrl, two_oct;
  logic [7:0]       c0_q, c0_eff;
  hdr_fields_t      dec, fld_q;
  logic [OFF_W-1:0] hdr_len_d, hdr_len_q;
  logic [CNT_W-1:0] hdr_len_w;
  logic             hdr_known_q, room_ok;
  logic [15:0]      last2;
  logic             hv_q, done_q, err_q;
  logic [CNT_W-1:0] info_len_q;
  logic [15:0]      fcs_q;

  hdlc_pos_counter #(.CNT_W(CNT_W)) u_pos (
    .clk_i, .rst_ni, .byte_valid_i, .sof_i, .eof_i,
    .take_o(take), .pos_o(pos)
  );

  hdlc_octet_hist u_hist (
    .clk_i, .rst_ni, .take_i(take), .byte_i, .last2_o(last2)
  );

  assign mode_eff = sof_i ? mode_i : mode_q;
  assign ext_seq  = (mode_eff != MODE_SEQ8);
  assign addr_len = mode_eff[1] ? CNT_W'(2) : CNT_W'(1);
  assign at_c0    = (pos == addr_len);
  assign c0_eff   = at_c0 ? byte_i : c0_q;

  hdlc_ctrl_decode u_dec (
    .ext_seq_i(ext_seq), .c0_i(c0_eff), .c1_i(byte_i),
    .fld_o(dec), .two_oct_o(two_oct)
  );

  assign last_ctrl = take && (two_oct ? (pos == addr_len + CNT_W'(1)) : at_c0);
  assign hdr_len_d = OFF_W'(addr_len) + (two_oct ? OFF_W'(2) : OFF_W'(1));
  assign hdr_len_w = CNT_W'(hdr_len_q);
  // header known and header+2 octets present once pos reaches hdr_len+1
  assign room_ok   = hdr_known_q && (pos >= hdr_len_w + CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= '0;
      c0_q        <= '0;
      fld_q       <= '0;
      hdr_len_q   <= '0;
      hdr_known_q <= 1'b0;
    end else if (take) begin
      if (sof_i) begin
        mode_q      <= mode_i;
        hdr_known_q <= 1'b0;
      end
      if (at_c0) c0_q <= byte_i;
      if (last_ctrl) begin
        fld_q       <= dec;
        hdr_len_q   <= hdr_len_d;
        hdr_known_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hv_q       <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      info_len_q <= '0;
      fcs_q      <= '0;
    end else begin
      hv_q   <= take && hdr_known_q && (pos == hdr_len_w + CNT_W'(1));
      done_q <= take && eof_i && room_ok;
      err_q  <= take && eof_i && !room_ok;
      if (take && eof_i && room_ok) begin
        info_len_q <= pos - hdr_len_w - CNT_W'(1);
        fcs_q      <= last2;
      end
    end
  end

  assign hdr_valid_o  = hv_q;
  assign frame_type_o = fld_q.ftype;
  assign ns_o         = fld_q.ns;
  assign nr_o         = fld_q.nr;
  assign pf_o         = fld_q.pf;
  assign s_code_o     = fld_q.s_code;
  assign u_mod_o      = fld_q.u_mod;
  assign rsvd_warn_o  = fld_q.rsvd_warn;
  assign info_off_o   = hdr_len_q;
  assign frame_done_o = done_q;
  assign info_len_o   = info_len_q;
  assign fcs_o        = fcs_q;
  assign short_err_o  = err_q;
endmodule

// File: rtl/hdlc_hdr_parser_chk.sv
module hdlc_hdr_parser_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hdr_valid_o,
  input logic [1:0] frame_type_o,
  input logic [6:0] ns_o,
  input logic [6:0] nr_o,
  input logic [1:0] s_code_o,
  input logic       rsvd_warn_o,
  input logic [2:0] info_off_o,
  input logic       frame_done_o,
  input logic       short_err_o
);
  AST_OFF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> (info_off_o >= 3'd2 && info_off_o <= 3'd4)); // R1
  AST_TYPE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> (frame_type_o != 2'b11)); // R2
  AST_U_NO_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_o && frame_type_o == 2'b10) |-> (ns_o == '0 && nr_o == '0 && s_code_o == '0)); // R4
  AST_WARN_S_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_o && rsvd_warn_o) |-> (frame_type_o == 2'b01 && info_off_o >= 3'd3)); // R6
  AST_HV_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |=> !hdr_valid_o); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o); // R8
  AST_SHORT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_err_o |-> (!frame_done_o && !hdr_valid_o)); // R9
endmodule

bind hdlc_hdr_parser hdlc_hdr_parser_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hdr_valid_o(hdr_valid_o),
  .frame_type_o(frame_type_o), .ns_o(ns_o), .nr_o(nr_o),
  .s_code_o(s_code_o), .rsvd_warn_o(rsvd_warn_o), .info_off_o(info_off_o),
  .frame_done_o(frame_done_o), .short_err_o(short_err_o)
);

// File: tb/hdlc_hdr_parser_tb.sv
`timescale 1ns/1ps
module hdlc_hdr_parser_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = '0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        sof_i = 1'b0, eof_i = 1'b0;
  logic        hdr_valid_o, pf_o, rsvd_warn_o, frame_done_o, short_err_o;
  logic [1:0]  frame_type_o, s_code_o;
  logic [6:0]  ns_o, nr_o;
  logic [4:0]  u_mod_o;
  logic [2:0]  info_off_o;
  logic [11:0] info_len_o;
  logic [15:0] fcs_o;

  int n_chk = 0, n_err = 0;
  bit gaps = 1'b0;
  logic [7:0] fb [64];
  int e_hdr, e_type, e_ns, e_nr, e_pf, e_s, e_u, e_w;

  always #4 clk_i = ~clk_i;

  hdlc_hdr_parser u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic void calc_exp(input int m, input int len);
    int al, c0, c1;
    bit two;
    al = (m >= 2) ? 2 : 1;
    e_ns = 0; e_nr = 0; e_pf = 0; e_s = 0; e_u = 0; e_w = 0;
    if (len <= al) begin e_hdr = 100; e_type = 0; return; end
    c0 = fb[al]; c1 = fb[al+1];
    e_type = (c0[0] == 1'b0) ? 0 : (c0[1] ? 2 : 1);
    two = (m != 0) && (e_type != 2);
    e_hdr = al + (two ? 2 : 1);
    if (e_type == 2) begin
      e_u = {c0[7:5], c0[3:2]}; e_pf = c0[4];
    end else if (!two) begin
      e_nr = c0[7:5]; e_pf = c0[4];
      if (e_type == 0) e_ns = c0[3:1]; else e_s = c0[3:2];
    end else begin
      e_nr = c1[7:1]; e_pf = c1[0];
      if (e_type == 0) e_ns = c0[7:1];
      else begin e_s = c0[3:2]; e_w = (c0[7:4] != 0); end
    end
  endfunction

  task automatic idle();
    @(negedge clk_i);
    byte_valid_i = 1'b0;
    sof_i = $urandom_range(1);
    eof_i = $urandom_range(1);
    byte_i = $urandom;
    mode_i = $urandom;
    @(posedge clk_i); #1;
    chk(!hdr_valid_o && !frame_done_o && !short_err_o, "R10 idle", {hdr_valid_o, frame_done_o, short_err_o}, 0);
  endtask

  task automatic send(input int m, input int len, input bit do_eof);
    bit ehv, edone;
    calc_exp(m, len);
    for (int i = 0; i < len; i++) begin
      if (gaps && $urandom_range(3) == 0) idle();
      @(negedge clk_i);
      byte_valid_i = 1'b1;
      byte_i = fb[i];
      sof_i = (i == 0);
      eof_i = do_eof && (i == len - 1);
      mode_i = (i == 0) ? m[1:0] : 2'($urandom);   // R10 mode ignored off start
      @(posedge clk_i); #1;
      ehv = (e_hdr < 100) && (i == e_hdr + 1);
      chk(hdr_valid_o == ehv, "R7 hdr_valid timing", hdr_valid_o, ehv);
      if (ehv) begin
        chk(info_off_o == e_hdr, "R1 info_off", info_off_o, e_hdr);
        chk(frame_type_o == e_type, "R2 type", frame_type_o, e_type);
        chk(ns_o == e_ns, "R3/R5 ns", ns_o, e_ns);
        chk(nr_o == e_nr, "R3/R5 nr", nr_o, e_nr);
        chk(pf_o == e_pf, "R3/R4/R5 pf", pf_o, e_pf);
        chk(s_code_o == e_s, "R3/R5 s_code", s_code_o, e_s);
        chk(u_mod_o == e_u, "R4 u_mod", u_mod_o, e_u);
        chk(rsvd_warn_o == e_w, "R6 warn", rsvd_warn_o, e_w);
      end
      if (eof_i) begin
        edone = (e_hdr < 100) && (len >= e_hdr + 2);
        chk(frame_done_o == edone, "R8 frame_done", frame_done_o, edone);
        chk(short_err_o == !edone, "R9 short_err", short_err_o, !edone);
        if (edone) begin
          chk(info_len_o == len - e_hdr - 2, "R8 info_len", info_len_o, len - e_hdr - 2);
          chk(fcs_o == {fb[len-2], fb[len-1]}, "R8 fcs", fcs_o, {fb[len-2], fb[len-1]});
        end
      end else begin
        chk(!frame_done_o && !short_err_o, "R8/R9 no end pulse", {frame_done_o, short_err_o}, 0);
      end
    end
    @(negedge clk_i);
    byte_valid_i = 1'b0; sof_i = 1'b0; eof_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #20;
    chk(!hdr_valid_o && !frame_done_o && !short_err_o && fcs_o == 0,
        "R7 reset state", {hdr_valid_o, frame_done_o, short_err_o}, 0);
    rst_ni = 1'b1;
    // R3 3-bit I: nr=5 p=1 ns=3
    fb[0] = 8'h03; fb[1] = 8'hB6; fb[2] = 8'h11; fb[3] = 8'hAB; fb[4] = 8'hCD;
    send(0, 5, 1);
    // R6 R5 7-bit S with reserved bits, nr=0x55 f=1
    fb[0] = 8'h01; fb[1] = 8'hF5; fb[2] = 8'hAB; fb[3] = 8'h12; fb[4] = 8'h34;
    send(1, 5, 1);
    // R4 two-octet address U frame, empty information field
    fb[0] = 8'h02; fb[1] = 8'h01; fb[2] = 8'h7F; fb[3] = 8'h9A; fb[4] = 8'hBC;
    send(2, 5, 1);
    // R9 two-octet address I frame one octet short
    fb[2] = 8'h10; fb[3] = 8'h21;
    send(2, 5, 1);
    // R9 single octet frame
    send(0, 1, 1);
    // R10 stray octets outside a frame
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      byte_valid_i = 1'b1; sof_i = 1'b0; eof_i = 1'b1; byte_i = $urandom;
      @(posedge clk_i); #1;
      chk(!hdr_valid_o && !frame_done_o && !short_err_o, "R10 stray octet",
          {hdr_valid_o, frame_done_o, short_err_o}, 0);
    end
    // R10 restart: abandoned frame then a full one
    for (int k = 0; k < 64; k++) fb[k] = $urandom;
    send(1, 7, 0);
    send(2, 9, 1);
    gaps = 1'b1;
    for (int f = 0; f < 400; f++) begin
      for (int k = 0; k < 64; k++) fb[k] = $urandom;
      send($urandom_range(3), $urandom_range(24, 1), $urandom_range(7) != 0);
    end
    repeat (3) idle();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule